// File: doc/BRIEF.md
# Accumulator Instruction Cycle Sequencer

This block is the control unit and register datapath of a small accumulator processor that takes several cycles per instruction. It reaches memory through one port with a request/acknowledge handshake. Every memory access goes through two internal registers: an address register that drives the address pins, and a buffer register that catches read data or supplies write data. The sequencer steps through a fetch subcycle, an optional indirect subcycle, an execute subcycle and, between instructions, an interrupt subcycle. In the interrupt subcycle it pushes the program counter through a stack pointer and then jumps to a fixed handler address.

An instruction is one 16-bit word. It holds a 3-bit operation, an indirect flag and a 12-bit address. The operations are load, store, add, jump, jump-if-zero and return-from-interrupt. A processor status word holds five condition flags, an interrupt-enable bit and a supervisor bit. Only load and add change the flags. Programs see them only through jump-if-zero.

Top module: `icyc_sequencer`

## Requirements
- R1: While reset is held and after it is released, `psw_o` equals 7'h40: supervisor set, interrupts disabled, all flags clear. `mem_req` is low during reset. The first request after reset is a read at address 0.
- R2: An instruction word is {op[15:13], ind[12], addr[11:0]}. The op codes are 0 load, 1 store, 2 add, 3 jump, 4 jump-if-zero, 5 return-from-interrupt, and 6–7 do nothing. Fetch reads the word at PC and increments PC by one when that read is acknowledged.
- R3: Each access holds `mem_req` high, with `mem_addr`, `mem_we` and `mem_wdata` unchanged, until `mem_ack` arrives, for any number of wait cycles.
- R4: Load sets ACC to the operand word. Add sets ACC to (ACC + operand) mod 2^16. Store writes ACC to the effective address.
- R5: `psw_o[4:0]` is {equal, overflow, carry, sign, zero}. Load and add update it: zero when the result is 0, sign is the result's bit 15, carry out of bit 15 (0 for load), signed overflow (0 for load), equal when the old ACC equals the operand. No other operation changes these five bits.
- R6: When ind=1, the word at addr is read first and its low 12 bits become the effective address. Its upper 4 bits are ignored.
- R7: Jump loads PC with the effective address. Jump-if-zero does so only when the zero flag is 1, and otherwise execution continues at the next word.
- R8: The interrupt request is sampled only after an instruction completes, and only when interrupt-enable (`psw_o[5]`) is 1. With interrupt-enable at 0 the request has no effect.
- R9: On interrupt entry the stack pointer is decremented and PC is written to the new stack address. `psw_o[5]` clears and `psw_o[6]` sets, and fetch resumes at the handler address (default 0x080). The stack pointer resets to 0x100.
- R10: Return-from-interrupt reads the word at the stack pointer and loads PC from its low 12 bits. It then increments the stack pointer, sets interrupt-enable and clears supervisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq | input | 1 | Level interrupt request |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 12 | Access address (address register) |
| mem_wdata | output | 16 | Write data (buffer register) |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access complete |
| psw_o | output | 7 | Status word {supervisor, int-enable, equal, overflow, carry, sign, zero} |

## Verification
Add is swept over every ordered pair from a set of operands chosen at the carry, overflow, sign and zero edges. Each flag is compared with a value the bench computes itself, so a wrong bit or a swapped flag shows up. Jump-if-zero runs with zero, small positive and negative accumulators, which separates the taken path from the fall-through path. Indirect runs use pointer words with nonzero upper bits, which exposes any use of more than 12 address bits. Interrupt runs hold the request first with interrupts disabled and then enabled. The pushed address and data, the status bits at the push, and a second push landing at the same slot together show that stack push and pop are balanced. Memory latency is varied from 0 to 3 wait cycles across all runs.

// File: rtl/icyc_pkg.sv
package icyc_pkg;

  localparam int OPW = 3;

  typedef enum logic [OPW-1:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_ADD   = 3'd2,
    OP_JUMP  = 3'd3,
    OP_JZ    = 3'd4,
    OP_RETI  = 3'd5,
    OP_NOP6  = 3'd6,
    OP_NOP7  = 3'd7
  } op_t;

  typedef enum logic [3:0] {
    S_FADR  = 4'd0,   // address register <- PC
    S_FRD   = 4'd1,   // instruction read, PC increments on ack
    S_FIR   = 4'd2,   // IR <- buffer
    S_IADR  = 4'd3,   // address register <- pointer field
    S_IRD   = 4'd4,   // pointer read
    S_EXE   = 4'd5,   // decode / dispatch
    S_ORD   = 4'd6,   // operand read
    S_ALU   = 4'd7,   // accumulator + flags write
    S_OWR   = 4'd8,   // operand write
    S_POP   = 4'd9,   // stack read for return
    S_CHK   = 4'd10,  // interrupt sample point
    S_IPUSH = 4'd11,  // prepare push
    S_IWR   = 4'd12   // push write
  } state_t;

  typedef struct packed {
    logic eq;
    logic ovf;
    logic cry;
    logic sgn;
    logic zro;
  } flags_t;

  typedef struct packed {
    logic   sup;
    logic   ie;
    flags_t cc;
  } psw_t;

endpackage

// File: rtl/icyc_alu.sv
module icyc_alu
  import icyc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          op_add,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] opnd,
  output logic [DW-1:0] res,
  output flags_t        flags
);

  // Returns {flags, result}; load passes the operand through the same path.
  function automatic logic [DW+4:0] alu_eval(input logic is_add,
                                             input logic [DW-1:0] a,
                                             input logic [DW-1:0] b);
    logic [DW:0]   sum;
    logic [DW-1:0] r;
    flags_t        f;
    sum   = {1'b0, a} + {1'b0, b};
    r     = is_add ? sum[DW-1:0] : b;
    f.zro = (r == '0);
    f.sgn = r[DW-1];
    f.cry = is_add & sum[DW];
    f.ovf = is_add & (a[DW-1] == b[DW-1]) & (r[DW-1] != a[DW-1]);
    f.eq  = (a == b);
    return {f, r};
  endfunction

  logic [DW+4:0] packed_out;

  always_comb begin
    packed_out = alu_eval(op_add, acc, opnd);
    res        = packed_out[DW-1:0];
    flags      = packed_out[DW+4:DW];
  end

endmodule

// File: rtl/icyc_psw.sv
module icyc_psw
  import icyc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   alu_wr,
  input  flags_t alu_flags,
  input  logic   int_enter,
  input  logic   reti_done,
  output psw_t   psw
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psw.cc  <= '0;
      psw.ie  <= 1'b0;
      psw.sup <= 1'b1;
    end else begin
      if (alu_wr) psw.cc <= alu_flags;
      if (int_enter) begin
        psw.ie  <= 1'b0;
        psw.sup <= 1'b1;
      end else if (reti_done) begin
        psw.ie  <= 1'b1;
        psw.sup <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/icyc_ctrl.sv
module icyc_ctrl
  import icyc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   mem_ack,
  input  op_t    op,
  input  logic   ind,
  input  logic   irq,
  input  logic   ie,
  output state_t state,
  output logic   mem_req,
  output logic   mem_we
);

  state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      S_FADR:  nxt = S_FRD;
      S_FRD:   if (mem_ack) nxt = S_FIR;
      S_FIR:   nxt = ind ? S_IADR : S_EXE;
      S_IADR:  nxt = S_IRD;
      S_IRD:   if (mem_ack) nxt = S_EXE;
      S_EXE: begin
        case (op)
          OP_LOAD, OP_ADD: nxt = S_ORD;
          OP_STORE:        nxt = S_OWR;
          OP_RETI:         nxt = S_POP;
          default:         nxt = S_CHK;
        endcase
      end
      S_ORD:   if (mem_ack) nxt = S_ALU;
      S_ALU:   nxt = S_CHK;
      S_OWR:   if (mem_ack) nxt = S_CHK;
      S_POP:   if (mem_ack) nxt = S_CHK;
      S_CHK:   nxt = (irq && ie) ? S_IPUSH : S_FADR;
      S_IPUSH: nxt = S_IWR;
      S_IWR:   if (mem_ack) nxt = S_FADR;
      default: nxt = S_FADR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_FADR;
    else        state <= nxt;
  end

  always_comb begin
    mem_req = (state == S_FRD) || (state == S_IRD) || (state == S_ORD) ||
              (state == S_OWR) || (state == S_POP) || (state == S_IWR);
    mem_we  = (state == S_OWR) || (state == S_IWR);
  end

endmodule

// File: rtl/icyc_sequencer.sv
module icyc_sequencer
  import icyc_pkg::*;
#(
  parameter int            AW        = 12,
  parameter int            DW        = 16,
  parameter logic [AW-1:0] STACK_TOP = 12'h100,
  parameter logic [AW-1:0] HANDLER   = 12'h080
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack,
  output logic [6:0]    psw_o
);

  localparam int IND_BIT = AW;
  localparam int OP_LSB  = AW + 1;
  localparam int PAD     = DW - AW;

  logic [AW-1:0] pc_q, mar_q, sp_q;
  logic [DW-1:0] mbr_q, ir_q, acc_q;
  logic [AW-1:0] ea;
  op_t           op;
  state_t        state;
  psw_t          psw;
  logic [DW-1:0] alu_res;
  flags_t        alu_flags;

  // named events for the checker
  logic ev_fetch_done, ev_alu_wr, ev_int_enter, ev_reti_done;

  assign ea            = mbr_q[AW-1:0];
  assign op            = op_t'(ir_q[DW-1:OP_LSB]);
  assign ev_fetch_done = (state == S_FRD) && mem_ack;
  assign ev_alu_wr     = (state == S_ALU);
  assign ev_int_enter  = (state == S_IPUSH);
  assign ev_reti_done  = (state == S_POP) && mem_ack;

  icyc_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .mem_ack (mem_ack),
    .op      (op),
    .ind     (mbr_q[IND_BIT]),
    .irq     (irq),
    .ie      (psw.ie),
    .state   (state),
    .mem_req (mem_req),
    .mem_we  (mem_we)
  );

  icyc_alu #(.DW(DW)) u_alu (
    .op_add (op == OP_ADD),
    .acc    (acc_q),
    .opnd   (mbr_q),
    .res    (alu_res),
    .flags  (alu_flags)
  );

  icyc_psw u_psw (
    .clk       (clk),
    .rst_n     (rst_n),
    .alu_wr    (ev_alu_wr),
    .alu_flags (alu_flags),
    .int_enter (ev_int_enter),
    .reti_done (ev_reti_done),
    .psw       (psw)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      mar_q <= '0;
      sp_q  <= STACK_TOP;
      mbr_q <= '0;
      ir_q  <= '0;
      acc_q <= '0;
    end else begin
      case (state)
        S_FADR: mar_q <= pc_q;
        S_FRD: if (mem_ack) begin
          mbr_q <= mem_rdata;
          pc_q  <= pc_q + 1'b1;
        end
        S_FIR:  ir_q  <= mbr_q;
        S_IADR: mar_q <= ea;
        S_IRD:  if (mem_ack) mbr_q <= mem_rdata;
        S_EXE: begin
          case (op)
            OP_LOAD, OP_ADD: mar_q <= ea;
            OP_STORE: begin
              mar_q <= ea;
              mbr_q <= acc_q;
            end
            OP_JUMP: pc_q  <= ea;
            OP_JZ:   if (psw.cc.zro) pc_q <= ea;
            OP_RETI: mar_q <= sp_q;
            default: ;
          endcase
        end
        S_ORD: if (mem_ack) mbr_q <= mem_rdata;
        S_ALU: acc_q <= alu_res;
        S_POP: if (mem_ack) begin
          pc_q <= mem_rdata[AW-1:0];
          sp_q <= sp_q + 1'b1;
        end
        S_IPUSH: begin
          mbr_q <= {{PAD{1'b0}}, pc_q};
          sp_q  <= sp_q - 1'b1;
          mar_q <= sp_q - 1'b1;
        end
        S_IWR: if (mem_ack) pc_q <= HANDLER;
        default: ;
      endcase
    end
  end

  assign mem_addr  = mar_q;
  assign mem_wdata = mbr_q;
  assign psw_o     = psw;

endmodule

// File: rtl/icyc_sequencer_chk.sv
module icyc_sequencer_chk #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_ack,
  input logic [6:0]    psw_o,
  input logic          ev_fetch_done,
  input logic          ev_alu_wr,
  input logic          ev_int_enter,
  input logic          ev_reti_done,
  input logic [AW-1:0] pc_q,
  input logic [AW-1:0] sp_q
);

  p_fetch_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fetch_done |=> pc_q == $past(pc_q) + 1'b1);

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) &&
                              $stable(mem_we) && $stable(mem_wdata));

  p_flags_only_alu_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_alu_wr |=> $stable(psw_o[4:0]));

  p_int_needs_ie_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_int_enter |-> psw_o[5]);

  p_int_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_int_enter |=> mem_req && mem_we && !psw_o[5] && psw_o[6] &&
                     (mem_addr == $past(sp_q) - 1'b1));

  p_reti_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reti_done |=> psw_o[5] && !psw_o[6] && (sp_q == $past(sp_q) + 1'b1));

endmodule

bind icyc_sequencer icyc_sequencer_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mem_req       (mem_req),
  .mem_we        (mem_we),
  .mem_addr      (mem_addr),
  .mem_wdata     (mem_wdata),
  .mem_ack       (mem_ack),
  .psw_o         (psw_o),
  .ev_fetch_done (ev_fetch_done),
  .ev_alu_wr     (ev_alu_wr),
  .ev_int_enter  (ev_int_enter),
  .ev_reti_done  (ev_reti_done),
  .pc_q          (pc_q),
  .sp_q          (sp_q)
);

// File: tb/sim_icyc_sequencer.sv
module sim_icyc_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int MW = 9;
  localparam logic [2:0] K_LD = 3'd0, K_ST = 3'd1, K_AD = 3'd2,
                         K_JP = 3'd3, K_JZ = 3'd4, K_RT = 3'd5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata = '0;
  logic [6:0]  psw_o;

  logic [15:0] mem [0:(1<<MW)-1];
  int lat = 0, wcnt = 0, nwrites = 0, stack_writes = 0, hold_err = 0;
  int sw_base = 0;
  logic irq_arm = 1'b0;
  logic seen_req = 1'b0;
  logic [11:0] first_addr = '0, a0 = '0, push_addr = '0;
  logic [15:0] d0 = '0, push_data = '0;
  logic w0 = 1'b0;
  logic [6:0] push_psw = '0;
  int checks = 0, errors = 0;

  assign irq = irq_arm && (stack_writes == sw_base);

  always #(CLK_PERIOD/2) clk = ~clk;

  icyc_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .irq(irq), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .psw_o(psw_o)
  );

  // memory model, acting on the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; wcnt <= 0; seen_req <= 1'b0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0; wcnt <= 0;
    end else if (mem_req) begin
      if (!seen_req) begin seen_req <= 1'b1; first_addr <= mem_addr; end
      if (wcnt == 0) begin a0 <= mem_addr; w0 <= mem_we; d0 <= mem_wdata; end
      else if (mem_addr != a0 || mem_we != w0 || mem_wdata != d0) hold_err <= hold_err + 1;
      if (wcnt >= lat) begin
        mem_ack <= 1'b1;
        if (mem_we) begin
          mem[mem_addr[MW-1:0]] <= mem_wdata;
          nwrites <= nwrites + 1;
          if (mem_addr >= 12'h0F8 && mem_addr <= 12'h100) begin
            stack_writes <= stack_writes + 1;
            push_addr <= mem_addr; push_data <= mem_wdata; push_psw <= psw_o;
          end
        end else begin
          mem_rdata <= mem[mem_addr[MW-1:0]];
        end
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  function automatic logic [15:0] ins(logic [2:0] op, logic ind, logic [11:0] a);
    return {op, ind, a};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < (1<<MW); i++) mem[i] = 16'h0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    irq_arm = 1'b0;
    repeat (3) @(negedge clk);
    nwrites = 0; stack_writes = 0; sw_base = 0;
    rst_n = 1'b1;
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  // bench-side model of add flags {eq, ovf, cry, sgn, zro}
  function automatic logic [4:0] add_flags(logic [15:0] a, logic [15:0] b);
    int s;
    logic [15:0] r;
    logic v;
    s = int'(a) + int'(b);
    r = s[15:0];
    v = (a[15] == b[15]) && (r[15] != a[15]);
    return {a == b, v, s > 65535, r[15], r == 16'h0};
  endfunction

  logic [15:0] vals [6];

  initial begin
    vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h7FFF;
    vals[3] = 16'h8000; vals[4] = 16'hFFFF; vals[5] = 16'h1234;

    // R1 reset state
    clear_mem();
    mem[0] = ins(K_JP, 1'b0, 12'h000);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(psw_o == 7'h40, "R1 psw in reset", psw_o, 7'h40);
    check(mem_req == 1'b0, "R1 req low in reset", mem_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(psw_o == 7'h40, "R1 psw after reset", psw_o, 7'h40);
    run(20);
    check(seen_req && first_addr == 12'h000, "R1 first fetch address", first_addr, 0);

    // R4 R5 R2 add sweep with varying latency
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 6; j++) begin
        logic [15:0] s;
        logic [4:0] ef;
        clear_mem();
        mem[0] = ins(K_LD, 1'b0, 12'h040);
        mem[1] = ins(K_AD, 1'b0, 12'h041);
        mem[2] = ins(K_ST, 1'b0, 12'h042);
        mem[3] = ins(K_JP, 1'b0, 12'h003);
        mem[12'h40] = vals[i];
        mem[12'h41] = vals[j];
        lat = (i + j) % 4;
        do_reset();
        run(150);
        s = vals[i] + vals[j];
        ef = add_flags(vals[i], vals[j]);
        check(mem[12'h42] == s, "R4 add result", mem[12'h42], s);
        check(psw_o[4:0] == ef, "R5 add flags", psw_o[4:0], ef);
        check(nwrites == 1, "R2 sequential program single store", nwrites, 1);
      end
    end

    // R5 load flags (acc is 0 before the load)
    for (int i = 0; i < 6; i++) begin
      logic [4:0] ef;
      clear_mem();
      mem[0] = ins(K_LD, 1'b0, 12'h040);
      mem[1] = ins(K_ST, 1'b0, 12'h042);
      mem[2] = ins(K_JP, 1'b0, 12'h002);
      mem[12'h40] = vals[i];
      lat = i % 4;
      do_reset();
      run(100);
      ef = {vals[i] == 16'h0, 1'b0, 1'b0, vals[i][15], vals[i] == 16'h0};
      check(psw_o[4:0] == ef, "R5 load flags", psw_o[4:0], ef);
      check(mem[12'h42] == vals[i], "R4 load/store", mem[12'h42], vals[i]);
    end

    // R6 indirect load and store, upper pointer bits ignored
    for (int l = 0; l < 4; l += 2) begin
      clear_mem();
      mem[0] = ins(K_LD, 1'b1, 12'h050);
      mem[1] = ins(K_ST, 1'b1, 12'h051);
      mem[2] = ins(K_JP, 1'b0, 12'h002);
      mem[12'h50] = 16'hF060;
      mem[12'h51] = 16'hA070;
      mem[12'h60] = 16'hBEEF;
      lat = l;
      do_reset();
      run(120);
      check(mem[12'h70] == 16'hBEEF, "R6 indirect store target", mem[12'h70], 16'hBEEF);
      check(mem[12'h60] == 16'hBEEF && mem[12'h51] == 16'hA070, "R6 pointers untouched",
            mem[12'h51], 16'hA070);
    end

    // R7 jump-if-zero taken / not taken
    for (int i = 0; i < 4; i++) begin
      logic [15:0] v, e;
      v = vals[i];
      clear_mem();
      mem[0] = ins(K_LD, 1'b0, 12'h040);
      mem[1] = ins(K_JZ, 1'b0, 12'h005);
      mem[2] = ins(K_LD, 1'b0, 12'h041);
      mem[3] = ins(K_ST, 1'b0, 12'h042);
      mem[4] = ins(K_JP, 1'b0, 12'h004);
      mem[5] = ins(K_LD, 1'b0, 12'h043);
      mem[6] = ins(K_ST, 1'b0, 12'h042);
      mem[7] = ins(K_JP, 1'b0, 12'h007);
      mem[12'h40] = v; mem[12'h41] = 16'h1111; mem[12'h43] = 16'h2222;
      lat = i;
      do_reset();
      run(160);
      e = (v == 16'h0) ? 16'h2222 : 16'h1111;
      check(mem[12'h42] == e, "R7 jump-if-zero path", mem[12'h42], e);
    end

    // R7 unconditional jump skips a store
    clear_mem();
    mem[0] = ins(K_JP, 1'b0, 12'h002);
    mem[1] = ins(K_ST, 1'b0, 12'h045);
    mem[2] = ins(K_JP, 1'b0, 12'h002);
    mem[12'h45] = 16'h5555;
    lat = 1;
    do_reset();
    run(80);
    check(mem[12'h45] == 16'h5555 && nwrites == 0, "R7 jump skips store", nwrites, 0);

    // R8 request ignored while interrupts are disabled
    clear_mem();
    mem[0] = ins(K_LD, 1'b0, 12'h040);
    mem[1] = ins(K_ST, 1'b0, 12'h042);
    mem[2] = ins(K_JP, 1'b0, 12'h002);
    mem[12'h40] = 16'h0ABC;
    mem[12'h0FF] = 16'hDEAD;
    lat = 2;
    do_reset();
    irq_arm = 1'b1;
    run(150);
    check(stack_writes == 0 && mem[12'h0FF] == 16'hDEAD, "R8 no push with ie=0", stack_writes, 0);
    check(mem[12'h42] == 16'h0ABC && psw_o[5] == 1'b0, "R8 program unaffected", mem[12'h42], 16'h0ABC);
    irq_arm = 1'b0;

    // R9 R10 interrupt entry and return, twice
    for (int l = 0; l < 4; l += 3) begin
      clear_mem();
      mem[0] = ins(K_RT, 1'b0, 12'h000);
      mem[1] = ins(K_LD, 1'b0, 12'h040);
      mem[2] = ins(K_ST, 1'b0, 12'h042);
      mem[3] = ins(K_JP, 1'b0, 12'h003);
      mem[12'h080] = ins(K_LD, 1'b0, 12'h041);
      mem[12'h081] = ins(K_ST, 1'b0, 12'h043);
      mem[12'h082] = ins(K_RT, 1'b0, 12'h000);
      mem[12'h100] = 16'h0001;
      mem[12'h40] = 16'h0A0A; mem[12'h41] = 16'h0B0B;
      lat = l;
      do_reset();
      run(150);
      check(psw_o[6:5] == 2'b01, "R10 reti sets ie clears sup", psw_o[6:5], 1);
      check(mem[12'h42] == 16'h0A0A, "R10 reti resumes at popped PC", mem[12'h42], 16'h0A0A);
      for (int k = 0; k < 2; k++) begin
        sw_base = stack_writes;
        irq_arm = 1'b1;
        for (int t = 0; t < 200 && stack_writes == sw_base; t++) @(negedge clk);
        check(push_addr == 12'h100, "R9 push address", push_addr, 12'h100);
        check(push_data == 16'h0003, "R9 pushed PC", push_data, 3);
        check(push_psw[6:5] == 2'b10, "R9 psw at push", push_psw[6:5], 2);
        run(200);
        irq_arm = 1'b0;
        check(mem[12'h43] == 16'h0B0B, "R9 handler ran", mem[12'h43], 16'h0B0B);
        check(psw_o[6:5] == 2'b01 && stack_writes == k + 1, "R10 return from handler",
              stack_writes, k + 1);
        mem[12'h43] = 16'h0;
      end
    end

    check(hold_err == 0, "R3 request held stable until ack", hold_err, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule